// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit side of a small Ethernet MAC, seen by a processor as a memory-mapped window. The window holds two equal halves, each a packet buffer with its own length and command register. Software writes a frame into a buffer one 32-bit word at a time, sets the length, and then writes a command. One command streams the buffer out as a byte stream to the downstream MAC layer. The other command loads the six-byte station address from the start of the buffer.

Commands are serviced by a single engine. A command written to one buffer while the other buffer is being served waits for the engine and then runs. Each buffer has its own interrupt enable bit. One global enable, kept only in the lower half of the window, gates the one-cycle interrupt pulse for both buffers. Preamble, FCS, collision handling and PHY signalling belong to the layers downstream.

Top module: `dual_tx_ctrl`

## Requirements
- R1: Byte offsets within the 4 KB window: buffer 1 starts at 0x800. In each half, data words sit below offset 0x7F4, the length register is at 0x7F4 and the command register is at 0x7FC. The global enable is bit 31 of 0x7F8. Read data appears on `bus_rdata` in the cycle after `bus_rd`. Data words and length registers read back exactly as written.
- R2: Frame byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of data word k/4 of its buffer. A byte moves when `tx_valid` and `tx_ready` are both high. `tx_last` is high only on the final byte. Data and last hold steady while a byte waits for acceptance.
- R3: Writing a command word with bit 0 = 1 and bit 1 = 0 sends, from that buffer, as many bytes as the low 16 bits of that buffer's length register give.
- R4: A send with effective length 0 emits no byte but still completes. An effective length above 2036 is cut to 2036.
- R5: A command word with bits 0 and 1 both set loads `station_mac` from the first six buffer bytes, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. It emits no stream bytes.
- R6: When an operation completes, `irq` is high for exactly one cycle, in the cycle after completion. It rises only if bit 3 of that buffer's command register and the global enable are both 1.
- R7: Writes to offset 0xFF8 have no effect, and reads of it return 0.
- R8: Command bit 0 reads 1 from the accepted command until completion, and bit 1 also reads 1 for an address load. A write to the command register of a busy buffer is ignored entirely.
- R9: A command given while the other buffer is being served runs after it, so the two frames leave back to back in the order they were commanded.
- R10: A write whose `bus_strb` is not 4'hF changes nothing. A command write with bit 0 = 0 only updates bit 3 and starts nothing.
- R11: After reset, all registers and `station_mac` are 0, and `irq` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes; only 4'hF is accepted |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| station_mac | output | 48 | Programmed station address |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that software issues at most one bus access per cycle. They also assume that it does not rewrite a buffer's data or length while that buffer is busy. The downstream side may hold `tx_ready` low for any number of cycles. The bench keeps to these rules: every access is a separate two-cycle task, and the bench polls the command register until the busy bit clears before it touches that buffer again. The ready pattern varies between always high, stalled, and one cycle low in three, so the hold behaviour of the stream is exercised.

// File: rtl/txl_pkg.sv
package txl_pkg;

  localparam int NUM_BUF = 2;
  localparam int LEN_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EMIT,
    ST_DONE
  } eng_state_t;

  // byte k of a frame lives in lane k mod 4, lane 0 in the low bits
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  // only the low 16 bits of the length register count, capped at the data area
  function automatic logic [LEN_W-1:0] clamp_len(input logic [31:0] raw,
                                                 input logic [LEN_W-1:0] cap);
    logic [LEN_W-1:0] lo;
    lo = raw[LEN_W-1:0];
    return (lo > cap) ? cap : lo;
  endfunction

  // buffer byte 0 lands in the top octet of the station address
  function automatic logic [47:0] mac_from_words(input logic [31:0] w0, input logic [31:0] w1);
    return {w0[7:0], w0[15:8], w0[23:16], w0[31:24], w1[7:0], w1[15:8]};
  endfunction

  function automatic logic [31:0] ctrl_view(input logic ie, input logic busy, input logic prog);
    return {28'd0, ie, 1'b0, busy & prog, busy};
  endfunction

endpackage

// File: rtl/txl_ram.sv
module txl_ram #(
  parameter int WORDS = 1024,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [31:0]   a_data,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [31:0]   b_data
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // port a serves the bus, port b the transmit engine
  always_ff @(posedge clk) begin
    if (a_en) a_data <= mem[a_addr];
    if (b_en) b_data <= mem[b_addr];
  end

endmodule

// File: rtl/txl_slot.sv
module txl_slot
  import txl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        len_we,
  input  logic        ctrl_we,
  input  logic [31:0] wdata,
  input  logic        done,
  output logic [31:0] len_q,
  output logic        ie_q,
  output logic        busy_q,
  output logic        prog_q,
  output logic [31:0] ctrl_rd
);

  logic cmd_accept;
  logic ctrl_blocked;

  assign cmd_accept   = ctrl_we && !busy_q && wdata[0];
  assign ctrl_blocked = ctrl_we && busy_q;
  assign ctrl_rd      = ctrl_view(ie_q, busy_q, prog_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      ie_q   <= 1'b0;
      busy_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      if (len_we) len_q <= wdata;
      if (done) begin
        busy_q <= 1'b0;
        prog_q <= 1'b0;
      end else if (ctrl_we && !busy_q) begin
        ie_q <= wdata[3];
        if (cmd_accept) begin
          busy_q <= 1'b1;
          prog_q <= wdata[1];
        end
      end
    end
  end

  // R8: a command write to a busy buffer leaves it untouched
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_blocked && !done) |=> (busy_q && $stable(ie_q) && $stable(prog_q)));

  // R8: completion is the only way out of busy
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);

endmodule

// File: rtl/txl_engine.sv
module txl_engine
  import txl_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int WPB        = BUF_BYTES / 4,
  localparam int AW         = $clog2(NUM_BUF * WPB),
  localparam int WAW        = AW - 1,
  localparam int DATA_BYTES = BUF_BYTES - 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BUF-1:0]           busy,
  input  logic [NUM_BUF-1:0]           op_prog,
  input  logic [NUM_BUF-1:0][31:0]     len_in,
  input  logic [NUM_BUF-1:0]           ie,
  input  logic                         gie,
  output logic                         ram_en,
  output logic [AW-1:0]                ram_addr,
  input  logic [31:0]                  ram_data,
  output logic [7:0]                   tx_data,
  output logic                         tx_valid,
  output logic                         tx_last,
  input  logic                         tx_ready,
  output logic [NUM_BUF-1:0]           done,
  output logic [47:0]                  mac_q,
  output logic                         irq_q
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(DATA_BYTES);

  eng_state_t       state_q;
  logic             sel_q;
  logic             is_prog_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      word_q;
  logic [31:0]      w0_q;

  logic             pick;
  logic             any_req;
  logic [LEN_W-1:0] cand_len;
  logic             done_any;
  logic             prog_done;
  logic             beat;

  assign any_req  = |busy;
  assign pick     = busy[0] ? 1'b0 : 1'b1;
  assign cand_len = clamp_len(len_in[pick], CAP);

  assign tx_valid = (state_q == ST_EMIT);
  assign tx_data  = lane_byte(word_q, cnt_q[1:0]);
  assign tx_last  = tx_valid && (cnt_q == len_q - LEN_W'(1));
  assign beat     = tx_valid && tx_ready;

  assign ram_en   = (state_q == ST_FETCH);
  assign ram_addr = {sel_q, cnt_q[WAW+1:2]};

  assign done_any  = (state_q == ST_DONE);
  assign prog_done = done_any && is_prog_q;

  always_comb begin
    done = '0;
    if (done_any) done[sel_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= 1'b0;
      is_prog_q <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      word_q    <= '0;
      w0_q      <= '0;
      mac_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (any_req) begin
            sel_q     <= pick;
            cnt_q     <= '0;
            is_prog_q <= op_prog[pick];
            len_q     <= cand_len;
            state_q   <= (!op_prog[pick] && cand_len == '0) ? ST_DONE : ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (is_prog_q) begin
            if (cnt_q == '0) begin
              w0_q    <= ram_data;
              cnt_q   <= LEN_W'(4);
              state_q <= ST_FETCH;
            end else begin
              mac_q   <= mac_from_words(w0_q, ram_data);
              state_q <= ST_DONE;
            end
          end else begin
            word_q  <= ram_data;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (tx_ready) begin
            if (tx_last) begin
              state_q <= ST_DONE;
            end else begin
              cnt_q <= cnt_q + LEN_W'(1);
              if (cnt_q[1:0] == 2'b11) state_q <= ST_FETCH;
            end
          end
        end
        ST_DONE: begin
          irq_q   <= ie[sel_q] & gie;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a byte waiting for acceptance does not move
  assert_stream_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_last_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R5: an address load never drives the stream, and only it moves the address
  assert_prog_no_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !is_prog_q);

  assert_mac_only_on_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mac_q) |-> prog_done);

  // R6: single-cycle pulse, right after a completion, with the global enable set
  assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_irq_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(done_any) && $past(gie)));

  // R4: the engine never counts past the capped length
  assert_len_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (cnt_q < CAP));

endmodule

// File: rtl/dual_tx_ctrl.sv
module dual_tx_ctrl
  import txl_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int ADDR_W = $clog2(NUM_BUF * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_strb,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [47:0]       station_mac,
  output logic              irq
);

  localparam int OFF_W  = ADDR_W - 1;
  localparam int WORDS  = NUM_BUF * BUF_BYTES / 4;
  localparam int RAW    = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LEN_OFF  = OFF_W'(BUF_BYTES - 12);
  localparam logic [OFF_W-1:0] GIE_OFF  = OFF_W'(BUF_BYTES - 8);
  localparam logic [OFF_W-1:0] CTRL_OFF = OFF_W'(BUF_BYTES - 4);

  logic             bsel;
  logic [OFF_W-1:0] off;
  logic             wr_ok;
  logic             is_data, is_len, is_gie, is_ctrl;

  assign bsel    = bus_addr[ADDR_W-1];
  assign off     = bus_addr[OFF_W-1:0];
  assign wr_ok   = bus_wr && (bus_strb == 4'hF);
  assign is_data = off < LEN_OFF;
  assign is_len  = off == LEN_OFF;
  assign is_gie  = off == GIE_OFF;
  assign is_ctrl = off == CTRL_OFF;

  logic [NUM_BUF-1:0][31:0] len_all;
  logic [NUM_BUF-1:0][31:0] ctrl_all;
  logic [NUM_BUF-1:0]       ie_all, busy_all, prog_all, done_all;
  logic [NUM_BUF-1:0]       len_we, ctrl_we;

  // one length/command pair per buffer
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    assign len_we[g]  = wr_ok && (bsel == 1'(g)) && is_len;
    assign ctrl_we[g] = wr_ok && (bsel == 1'(g)) && is_ctrl;
    txl_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .len_we  (len_we[g]),
      .ctrl_we (ctrl_we[g]),
      .wdata   (bus_wdata),
      .done    (done_all[g]),
      .len_q   (len_all[g]),
      .ie_q    (ie_all[g]),
      .busy_q  (busy_all[g]),
      .prog_q  (prog_all[g]),
      .ctrl_rd (ctrl_all[g])
    );
  end

  // global enable lives in the lower half only
  logic gie_q;
  logic gie_we;
  assign gie_we = wr_ok && !bsel && is_gie;

  always_ff @(posedge clk) begin
    if (!rst_n) gie_q <= 1'b0;
    else if (gie_we) gie_q <= bus_wdata[31];
  end

  logic          eng_en;
  logic [RAW-1:0] eng_addr;
  logic [31:0]   eng_data;
  logic [31:0]   bus_word;

  txl_ram #(.WORDS(WORDS)) u_ram (
    .clk    (clk),
    .we     (wr_ok && is_data),
    .waddr  (bus_addr[ADDR_W-1:2]),
    .wdata  (bus_wdata),
    .a_en   (bus_rd),
    .a_addr (bus_addr[ADDR_W-1:2]),
    .a_data (bus_word),
    .b_en   (eng_en),
    .b_addr (eng_addr),
    .b_data (eng_data)
  );

  txl_engine #(.BUF_BYTES(BUF_BYTES)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_all),
    .op_prog  (prog_all),
    .len_in   (len_all),
    .ie       (ie_all),
    .gie      (gie_q),
    .ram_en   (eng_en),
    .ram_addr (eng_addr),
    .ram_data (eng_data),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .done     (done_all),
    .mac_q    (station_mac),
    .irq_q    (irq)
  );

  // read path: register view captured with the same latency as the buffer RAM
  logic [31:0] reg_view;
  logic [31:0] reg_rd_q;
  logic        rd_data_q;

  always_comb begin
    reg_view = '0;
    if (is_len)              reg_view = len_all[bsel];
    else if (is_ctrl)        reg_view = ctrl_all[bsel];
    else if (is_gie && !bsel) reg_view = {gie_q, 31'd0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_q  <= '0;
      rd_data_q <= 1'b0;
    end else if (bus_rd) begin
      reg_rd_q  <= reg_view;
      rd_data_q <= is_data;
    end
  end

  assign bus_rdata = rd_data_q ? bus_word : reg_rd_q;

  // R10: strobes other than all-ones leave every register alone
  assert_strb_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_strb != 4'hF) |=> ($stable(gie_q) && $stable(len_all) && $stable(ie_all)));

  // R7: the upper-half enable slot is inert
  assert_upper_gie_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bsel && is_gie) |=> $stable(gie_q));

  // R9: one engine, so at most one buffer completes per cycle
  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_all));

endmodule

// File: tb/sim_dual_tx_ctrl.sv
module sim_dual_tx_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 2048;
  localparam int ADDR_W     = 12;
  localparam int DATA_WORDS = (BUF_BYTES - 12) / 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [3:0]        bus_strb = '0;
  logic [31:0]       bus_rdata;
  logic [7:0]        tx_data;
  logic              tx_valid;
  logic              tx_last;
  logic              tx_ready = 1'b0;
  logic [47:0]       station_mac;
  logic              irq;

  dual_tx_ctrl #(.BUF_BYTES(BUF_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .station_mac(station_mac), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  // vector: buf(1) len(20) ctrl(4) gie(1) exp_len(16) exp_irq(1)
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 20'd5,       4'h9, 1'b1, 16'd5,    1'b1},
    {1'b1, 20'd8,       4'h9, 1'b0, 16'd8,    1'b0},
    {1'b1, 20'd3,       4'h9, 1'b1, 16'd3,    1'b1},
    {1'b0, 20'd1,       4'h1, 1'b1, 16'd1,    1'b0},
    {1'b0, 20'd0,       4'h9, 1'b1, 16'd0,    1'b1},
    {1'b1, 20'd4000,    4'h1, 1'b1, 16'd2036, 1'b0},
    {1'b0, 20'd7,       4'hB, 1'b1, 16'd0,    1'b1},
    {1'b1, 20'd0,       4'h3, 1'b1, 16'd0,    1'b0},
    {1'b0, 20'd4,       4'hA, 1'b1, 16'd0,    1'b0},
    {1'b0, 20'h10009,   4'h9, 1'b1, 16'd9,    1'b1}
  };

  // monitor
  int cyc = 0;
  int ready_mode = 1;
  int rx_cnt = 0, last_cnt = 0, last_idx = -1, irq_cnt = 0;
  logic [7:0] rx_buf [4096];

  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = 1'b0;
      default: tx_ready = (cyc % 3) != 0;
    endcase
    if (tx_valid && tx_ready) begin
      if (rx_cnt < 4096) rx_buf[rx_cnt] = tx_data;
      if (tx_last) begin
        last_cnt++;
        last_idx = rx_cnt;
      end
      rx_cnt++;
    end
    if (irq) irq_cnt++;
  end

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((i * 5) + (b * 8'h81) + 8'h3c);
  endfunction

  // R2 byte order: byte 4w+k in lane k
  function automatic logic [31:0] word_of(input int b, input int w);
    return {pat(b, 4*w+3), pat(b, 4*w+2), pat(b, 4*w+1), pat(b, 4*w)};
  endfunction

  function automatic logic [47:0] mac_of(input int b);
    return {pat(b,0), pat(b,1), pat(b,2), pat(b,3), pat(b,4), pat(b,5)};
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d; bus_strb = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_strb = 4'h0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clear_rx();
    rx_cnt = 0; last_cnt = 0; last_idx = -1; irq_cnt = 0;
  endtask

  task automatic wait_idle(input int b);
    logic [31:0] d;
    for (int n = 0; n < 20000; n++) begin
      bus_read(b * 'h800 + 'h7FC, d);
      if (d[0] == 1'b0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_bytes(input string req, input int b, input int start, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++)
      if (rx_buf[start + i] !== pat(b, i)) bad++;
    chk(req, 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] exp_mac;
    exp_mac = '0;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq", 64'(irq), 64'd0);
    chk("R11 tx_valid", 64'(tx_valid), 64'd0);
    chk("R11 mac", 64'(station_mac), 64'd0);
    rst_n = 1'b1;
    bus_read('h7FC, d); chk("R11 ctrl0", 64'(d), 64'd0);
    bus_read('h7F4, d); chk("R11 len0", 64'(d), 64'd0);
    bus_read('h7F8, d); chk("R11 gie", 64'(d), 64'd0);

    // fill both buffers
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < DATA_WORDS; w++)
        bus_write(b * 'h800 + 4 * w, word_of(b, w), 4'hF);

    // R1 readback
    bus_read('h800, d);   chk("R1 data buf1 w0", 64'(d), 64'(word_of(1, 0)));
    bus_read('h7F0, d);   chk("R1 data buf0 last word", 64'(d), 64'(word_of(0, DATA_WORDS-1)));
    bus_write('hFF4, 32'hCAFE_0123, 4'hF);
    bus_read('hFF4, d);   chk("R1 len1", 64'(d), 64'h0000_0000_CAFE_0123);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int b, len, el, ei;
      logic [3:0] c;
      string tag;
      b  = int'(VEC[v][42]);
      len = int'(VEC[v][41:22]);
      c  = VEC[v][21:18];
      el = int'(VEC[v][16:1]);
      ei = int'(VEC[v][0]);
      ready_mode = (v % 2 == 0) ? 0 : 2;
      clear_rx();
      bus_write('h7F8, {VEC[v][17], 31'd0}, 4'hF);
      bus_write(b * 'h800 + 'h7F4, 32'(len), 4'hF);
      bus_write(b * 'h800 + 'h7FC, {28'd0, c}, 4'hF);
      wait_idle(b);
      if (c[1] && c[0]) begin
        exp_mac = mac_of(b);
        tag = "R5";
      end else if (!c[0]) tag = "R10";
      else if (el != len) tag = "R4";
      else tag = "R3";
      chk({tag, " byte count"}, 64'(rx_cnt), 64'(el));
      chk_bytes({tag, " R2 bytes"}, b, 0, el);
      chk("R2 last count", 64'(last_cnt), 64'((el > 0) ? 1 : 0));
      if (el > 0) chk("R2 last position", 64'(last_idx), 64'(el - 1));
      chk("R6 irq count", 64'(irq_cnt), 64'(ei));
      chk("R5 station_mac", 64'(station_mac), 64'(exp_mac));
      bus_read(b * 'h800 + 'h7FC, d);
      chk("R8 ctrl after completion", 64'(d), 64'({28'd0, c[3], 3'b000}));
    end

    // R8 busy readback, busy write ignored; R9 queued second buffer
    ready_mode = 1;
    clear_rx();
    bus_write('h7F8, 32'h8000_0000, 4'hF);
    bus_write('h7F4, 32'd3, 4'hF);
    bus_write('hFF4, 32'd2, 4'hF);
    bus_write('h7FC, 32'h1, 4'hF);
    bus_read('h7FC, d); chk("R8 send busy readback", 64'(d), 64'h1);
    bus_write('h7FC, 32'hB, 4'hF);
    bus_read('h7FC, d); chk("R8 busy write ignored", 64'(d), 64'h1);
    bus_write('hFFC, 32'h9, 4'hF);
    bus_read('hFFC, d); chk("R9 queued readback", 64'(d), 64'h9);
    chk("R8 stalled no bytes", 64'(rx_cnt), 64'd0);
    ready_mode = 0;
    wait_idle(0);
    wait_idle(1);
    chk("R9 total bytes", 64'(rx_cnt), 64'd5);
    chk_bytes("R9 first frame buf0", 0, 0, 3);
    chk_bytes("R9 second frame buf1", 1, 3, 2);
    chk("R9 two lasts", 64'(last_cnt), 64'd2);
    chk("R6 only buf1 interrupts", 64'(irq_cnt), 64'd1);
    chk("R8 mac unchanged", 64'(station_mac), 64'(exp_mac));

    // R8 address load busy readback
    ready_mode = 1;
    bus_write('hFFC, 32'h3, 4'hF);
    bus_read('hFFC, d);
    chk("R8 prog readback", 64'(d & 32'h3), (d[0] ? 64'h3 : 64'h0));
    wait_idle(1);
    exp_mac = mac_of(1);
    chk("R5 mac from buf1", 64'(station_mac), 64'(exp_mac));

    // R10 partial strobes
    bus_write('h7F4, 32'h1234, 4'hF);
    bus_write('h7F4, 32'hFFFF, 4'h3);
    bus_read('h7F4, d); chk("R10 len partial ignored", 64'(d), 64'h1234);
    bus_write('h7F8, 32'h0, 4'hF);
    bus_write('h7F8, 32'h8000_0000, 4'h8);
    bus_read('h7F8, d); chk("R10 gie partial ignored", 64'(d), 64'h0);
    clear_rx();
    bus_write('h7FC, 32'h9, 4'h7);
    repeat (6) @(negedge clk);
    bus_read('h7FC, d); chk("R10 partial ctrl ignored", 64'(d), 64'h0);

    // R7 upper enable slot inert
    ready_mode = 0;
    clear_rx();
    bus_write('hFF8, 32'h8000_0000, 4'hF);
    bus_read('hFF8, d); chk("R7 upper gie reads 0", 64'(d), 64'h0);
    bus_read('h7F8, d); chk("R7 lower gie untouched", 64'(d), 64'h0);
    bus_write('hFF4, 32'd2, 4'hF);
    bus_write('hFFC, 32'h9, 4'hF);
    wait_idle(1);
    chk("R7 no irq via upper slot", 64'(irq_cnt), 64'd0);
    chk("R3 bytes with gie off", 64'(rx_cnt), 64'd2);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule